// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit evaluates floating-point set-flag compare operations and keeps their outcome in a single registered condition flag. A compare is launched with a one-cycle valid strobe together with a function code and two operands. Each operand arrives as two 32-bit words. A single-precision compare reads only the first word. A double-precision compare joins both words into one 64-bit value, whether the operand came from a native 64-bit register or from a pair of 32-bit registers. No general register is written. The only results are the flag and an invalid-operation pulse.

Three predicate families are provided. The ordered family is eq, ne, gt, ge, lt and le. The unordered-or family sets the flag when either operand is NaN or when the plain relation holds. A standalone unordered test sets the flag only when a NaN is present.

For the register-pair operand form, the unit also computes the index of the second register of each source pair from the base index and its offset bit. The register file uses that index to fetch the second word.

Top module: `fcmp_flag_unit`

## Requirements
- R1: The function code is 8 bits. Bits [7:6] must be 00. Bit 5 selects the unordered-or family and bit 4 selects double precision. Low nibble values 0x8 to 0xD select eq, ne, gt, ge, lt and le in that order. Low nibble 0xE is the pure unordered test and is legal only when bit 5 is set. Any other code leaves the flag unchanged and gives no invalid pulse.
- R2: An ordered predicate gives false when either operand is NaN, except ne, which gives true.
- R3: An unordered-or predicate (codes 0x28 to 0x2D and 0x38 to 0x3D) sets the flag when either operand is NaN or when the relation is true.
- R4: The pure unordered test (0x2E single, 0x3E double) sets the flag if and only if at least one operand is NaN.
- R5: Positive zero and negative zero compare as equal.
- R6: A single-precision compare uses only the first word of each operand, and the second word has no effect. A double-precision compare uses the first word as bits [63:32] and the second word as bits [31:0].
- R7: The invalid output pulses one cycle after a legal compare when any operand is a signalling NaN. It also pulses when a quiet NaN meets an ordered gt, ge, lt or le. It is 0 in every other cycle.
- R8: The flag takes its new value on the first clock edge after the valid strobe and holds it while valid is low. Reset clears the flag.
- R9: Each pair index equals the base index plus 2 when the offset bit is 1, and plus 1 when it is 0, modulo 32.
- R10: Non-NaN values are ordered by signed magnitude, with infinities at the ends and subnormals between zero and the smallest normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Launches a compare this cycle |
| func_i | input | 8 | Compare function code |
| a_w0_i | input | 32 | Operand A first word (single value, or double high half) |
| a_w1_i | input | 32 | Operand A second word (double low half) |
| b_w0_i | input | 32 | Operand B first word |
| b_w1_i | input | 32 | Operand B second word |
| reg_a_i | input | 5 | Base register index of operand A |
| off_a_i | input | 1 | Pair offset bit of operand A |
| reg_b_i | input | 5 | Base register index of operand B |
| off_b_i | input | 1 | Pair offset bit of operand B |
| pair_a_o | output | 5 | Second register index of operand A pair |
| pair_b_o | output | 5 | Second register index of operand B pair |
| flag_o | output | 1 | Condition flag |
| inv_o | output | 1 | Invalid-operation pulse |

## Verification
Every legal code of all four families is swept over a grid of operand values in both precisions. The grid holds signed normals, both zeros, both infinities, subnormals and extreme magnitudes. This grid separates the sign-magnitude ordering and the zero equality from the relation choice. The same grid with quiet and signalling NaNs added separates the three families by their NaN rule, and shows which NaN kind raises the invalid pulse. In single-precision runs the second words carry junk, so any leak from the unused half shows up. Idle cycles and illegal codes follow a known flag value to show that the flag holds. The pair index is checked at the wrap-around boundary.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int DP_EXP = 11;
  localparam int DP_MAN = 52;
  localparam int FUNC_W = 8;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [2:0] {
    REL_EQ, REL_NE, REL_GT, REL_GE, REL_LT, REL_LE, REL_UN, REL_NONE
  } rel_e;

  typedef struct packed {
    logic legal;
    logic dbl;
    logic unord;
    rel_e rel;
  } fcmp_op_t;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } fclass_t;

  // Ordered relation from eq/lt, then NaN policy of the selected family.
  function automatic logic pred_eval(input rel_e rel, input logic unord,
                                     input logic un, input logic eq,
                                     input logic lt);
    logic ord;
    case (rel)
      REL_EQ:  ord = eq;
      REL_NE:  ord = !eq;
      REL_GT:  ord = !eq && !lt;
      REL_GE:  ord = !lt;
      REL_LT:  ord = lt;
      REL_LE:  ord = lt || eq;
      default: ord = 1'b0;
    endcase
    if (un) return unord || (rel == REL_NE);
    return (rel == REL_UN) ? 1'b0 : ord;
  endfunction

  // Quiet NaNs raise invalid only for ordered magnitude relations.
  function automatic logic inv_eval(input rel_e rel, input logic unord,
                                    input logic any_nan, input logic any_snan);
    logic relational;
    relational = (rel == REL_GT) || (rel == REL_GE) ||
                 (rel == REL_LT) || (rel == REL_LE);
    return any_snan || (any_nan && !unord && relational);
  endfunction
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output fcmp_op_t          op_o
);
  always_comb begin
    op_o.dbl   = func_i[4];
    op_o.unord = func_i[5];
    op_o.legal = 1'b0;
    op_o.rel   = REL_NONE;
    if (func_i[7:6] == 2'b00) begin
      case (func_i[3:0])
        4'h8: begin op_o.rel = REL_EQ; op_o.legal = 1'b1; end
        4'h9: begin op_o.rel = REL_NE; op_o.legal = 1'b1; end
        4'hA: begin op_o.rel = REL_GT; op_o.legal = 1'b1; end
        4'hB: begin op_o.rel = REL_GE; op_o.legal = 1'b1; end
        4'hC: begin op_o.rel = REL_LT; op_o.legal = 1'b1; end
        4'hD: begin op_o.rel = REL_LE; op_o.legal = 1'b1; end
        4'hE: if (func_i[5]) begin op_o.rel = REL_UN; op_o.legal = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W:0]   val_i,
  output fclass_t          cls_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;

  assign sign_o  = val_i[MAG_W];
  assign mag_o   = val_i[MAG_W-1:0];
  assign exp_f   = val_i[MAG_W-1:MAN_W];
  assign man_f   = val_i[MAN_W-1:0];
  assign exp_max = &exp_f;

  assign cls_o.nan  = exp_max && (man_f != '0);
  assign cls_o.snan = exp_max && (man_f != '0) && !man_f[MAN_W-1];
  assign cls_o.zero = (mag_o == '0);
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate #(
  parameter int MAG_W = 31
) (
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  input  logic             zero_both_i,
  output logic             eq_o,
  output logic             lt_o
);
  logic mag_lt, mag_gt, mag_eq;

  assign mag_lt = mag_a_i < mag_b_i;
  assign mag_gt = mag_a_i > mag_b_i;
  assign mag_eq = mag_a_i == mag_b_i;

  assign eq_o = zero_both_i || ((sign_a_i == sign_b_i) && mag_eq);

  always_comb begin
    if (zero_both_i)              lt_o = 1'b0;
    else if (sign_a_i != sign_b_i) lt_o = sign_a_i;
    else if (sign_a_i)            lt_o = mag_gt;
    else                          lt_o = mag_lt;
  end
endmodule

// File: rtl/fcmp_pair_index.sv
module fcmp_pair_index #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic             off_i,
  output logic [IDX_W-1:0] pair_o
);
  logic [IDX_W-1:0] step;
  assign step   = off_i ? IDX_W'(2) : IDX_W'(1);
  assign pair_o = base_i + step;
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [WORD_W-1:0] a_w0_i,
  input  logic [WORD_W-1:0] a_w1_i,
  input  logic [WORD_W-1:0] b_w0_i,
  input  logic [WORD_W-1:0] b_w1_i,
  input  logic [IDX_W-1:0]  reg_a_i,
  input  logic              off_a_i,
  input  logic [IDX_W-1:0]  reg_b_i,
  input  logic              off_b_i,
  output logic [IDX_W-1:0]  pair_a_o,
  output logic [IDX_W-1:0]  pair_b_o,
  output logic              flag_o,
  output logic              inv_o
);
  fcmp_op_t op;
  fclass_t  lane_ca [2];
  fclass_t  lane_cb [2];
  logic     lane_eq [2];
  logic     lane_lt [2];

  fcmp_decode u_dec (.func_i(func_i), .op_o(op));

  fcmp_pair_index #(.IDX_W(IDX_W)) u_pair_a (.base_i(reg_a_i), .off_i(off_a_i), .pair_o(pair_a_o));
  fcmp_pair_index #(.IDX_W(IDX_W)) u_pair_b (.base_i(reg_b_i), .off_i(off_b_i), .pair_o(pair_b_o));

  // Lane 0: single precision, lane 1: double precision.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int EW = (g == 0) ? SP_EXP : DP_EXP;
    localparam int MW = (g == 0) ? SP_MAN : DP_MAN;
    localparam int LW = 1 + EW + MW;
    logic [LW-1:0]   va, vb;
    logic [LW-2:0]   ma, mb;
    logic            sa, sb;
    fclass_t         ca, cb;
    if (g == 0) begin : g_sp
      assign va = a_w0_i;
      assign vb = b_w0_i;
    end else begin : g_dp
      assign va = {a_w0_i, a_w1_i};
      assign vb = {b_w0_i, b_w1_i};
    end
    fcmp_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_a (.val_i(va), .cls_o(ca), .sign_o(sa), .mag_o(ma));
    fcmp_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_b (.val_i(vb), .cls_o(cb), .sign_o(sb), .mag_o(mb));
    fcmp_relate #(.MAG_W(LW-1)) u_rel (
      .sign_a_i(sa), .sign_b_i(sb), .mag_a_i(ma), .mag_b_i(mb),
      .zero_both_i(ca.zero && cb.zero),
      .eq_o(lane_eq[g]), .lt_o(lane_lt[g])
    );
    assign lane_ca[g] = ca;
    assign lane_cb[g] = cb;
  end

  // Named events for the assertions.
  fclass_t ca_sel, cb_sel;
  logic    any_nan, any_snan, both_zero, launch, res_flag, res_inv;

  assign ca_sel    = op.dbl ? lane_ca[1] : lane_ca[0];
  assign cb_sel    = op.dbl ? lane_cb[1] : lane_cb[0];
  assign any_nan   = ca_sel.nan  || cb_sel.nan;
  assign any_snan  = ca_sel.snan || cb_sel.snan;
  assign both_zero = ca_sel.zero && cb_sel.zero;
  assign launch    = valid_i && op.legal;
  assign res_flag  = pred_eval(op.rel, op.unord, any_nan,
                               op.dbl ? lane_eq[1] : lane_eq[0],
                               op.dbl ? lane_lt[1] : lane_lt[0]);
  assign res_inv   = inv_eval(op.rel, op.unord, any_nan, any_snan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      inv_o  <= 1'b0;
    end else begin
      inv_o <= launch && res_inv;
      if (launch) flag_o <= res_flag;
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flag_o));
  p_inv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !inv_o);
  p_snan_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch && any_snan |=> inv_o);
  p_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !op.legal |=> $stable(flag_o) && !inv_o);
  p_unord_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch && op.unord && any_nan |=> flag_o);
  p_ordered_nan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !op.unord && any_nan && (op.rel != REL_NE) |=> !flag_o);
  p_un_test_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch && (op.rel == REL_UN) |=> flag_o == $past(any_nan));
  p_zero_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch && both_zero && (op.rel == REL_EQ) |=> flag_o);
endmodule

// File: tb/fcmp_flag_unit_test.sv
module fcmp_flag_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  func_i = '0;
  logic [31:0] a_w0_i = '0, a_w1_i = '0, b_w0_i = '0, b_w1_i = '0;
  logic [4:0]  reg_a_i = '0, reg_b_i = '0;
  logic        off_a_i = 1'b0, off_b_i = 1'b0;
  logic [4:0]  pair_a_o, pair_b_o;
  logic        flag_o, inv_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .func_i(func_i),
    .a_w0_i(a_w0_i), .a_w1_i(a_w1_i), .b_w0_i(b_w0_i), .b_w1_i(b_w1_i),
    .reg_a_i(reg_a_i), .off_a_i(off_a_i), .reg_b_i(reg_b_i), .off_b_i(off_b_i),
    .pair_a_o(pair_a_o), .pair_b_o(pair_b_o), .flag_o(flag_o), .inv_o(inv_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Operand grid: 0..9 ordinary values, 10 quiet NaN, 11 signalling NaN.
  function automatic logic [63:0] grid(input int i, input bit dbl);
    if (!dbl) case (i)
      0: return 64'h3f800000;  1: return 64'h40000000;
      2: return 64'hbf800000;  3: return 64'h00000000;
      4: return 64'h80000000;  5: return 64'h7f800000;
      6: return 64'hff800000;  7: return 64'h00000001;
      8: return 64'h7f7fffff;  9: return 64'hc0000000;
      10: return 64'h7fc00000; default: return 64'h7f800001;
    endcase
    case (i)
      0: return 64'h3ff0000000000000;  1: return 64'h4000000000000000;
      2: return 64'hbff0000000000000;  3: return 64'h0000000000000000;
      4: return 64'h8000000000000000;  5: return 64'h7ff0000000000000;
      6: return 64'hfff0000000000000;  7: return 64'h0000000000000001;
      8: return 64'hbfe0000000000000;  9: return 64'h0010000000000000;
      10: return 64'h7ff8000000000000; default: return 64'h7ff0000000000001;
    endcase
  endfunction

  function automatic bit is_nan(input logic [63:0] v, input bit dbl);
    if (dbl) return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [63:0] v, input bit dbl);
    if (dbl) return is_nan(v, 1'b1) && !v[51];
    return is_nan(v, 1'b0) && !v[22];
  endfunction

  // Value as a real, built from the fields for single precision.
  function automatic real to_real(input logic [63:0] v, input bit dbl);
    real mag;
    int  e;
    if (dbl) return $bitstoreal(v);
    if (v[30:23] == 8'hff)
      return (v[22:0] != 0) ? $bitstoreal(64'h7ff8000000000000)
           : $bitstoreal({v[31], 63'h7ff0000000000000});
    e   = (v[30:23] == 0) ? 1 : int'(v[30:23]);
    mag = real'(v[22:0]) + ((v[30:23] == 0) ? 0.0 : 8388608.0);
    mag = mag * (2.0 ** (real'(e) - 150.0));
    return v[31] ? -mag : mag;
  endfunction

  // Drive one compare and check flag and invalid one clock later.
  task automatic apply(input logic [7:0] fc, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    bit   dbl, legal, un, relational;
    real  ra, rb;
    logic rel, ef, ei;
    dbl = fc[4];
    legal = (fc[7:6] == 0) && ((fc[3:0] >= 4'h8 && fc[3:0] <= 4'hD) ||
                               (fc[3:0] == 4'hE && fc[5]));
    un = is_nan(a, dbl) || is_nan(b, dbl);
    ra = to_real(a, dbl);
    rb = to_real(b, dbl);
    case (fc[3:0])
      4'h8: rel = (ra == rb);
      4'h9: rel = !(ra == rb);
      4'hA: rel = (ra > rb);
      4'hB: rel = (ra >= rb);
      4'hC: rel = (ra < rb);
      4'hD: rel = (ra <= rb);
      default: rel = 1'b0;
    endcase
    relational = (fc[3:0] >= 4'hA) && (fc[3:0] <= 4'hD);
    if (!legal) begin ef = exp_flag; ei = 1'b0; end
    else begin
      ef = fc[5] ? (un || rel) : rel;
      ei = is_snan(a, dbl) || is_snan(b, dbl) || (un && !fc[5] && relational);
    end
    @(negedge clk);
    func_i = fc; valid_i = 1'b1;
    if (dbl) begin
      a_w0_i = a[63:32]; a_w1_i = a[31:0]; b_w0_i = b[63:32]; b_w1_i = b[31:0];
    end else begin
      a_w0_i = a[31:0]; b_w0_i = b[31:0];
      a_w1_i = 32'h5a5a0000 ^ b[31:0]; b_w1_i = ~a[31:0];   // junk halves (R6)
    end
    @(negedge clk);
    valid_i = 1'b0;
    exp_flag = ef;
    check($sformatf("%s flag code=%0h a=%0h b=%0h", tag, fc, a, b), 32'(flag_o), 32'(ef));
    check($sformatf("R7 inv code=%0h a=%0h b=%0h", fc, a, b), 32'(inv_o), 32'(ei));
  endtask

  task automatic sweep(input logic [7:0] lo, input logic [7:0] hi, input int nvals,
                       input string tag);
    for (int c = int'(lo); c <= int'(hi); c++)
      for (int i = 0; i < nvals; i++)
        for (int j = 0; j < nvals; j++)
          apply(8'(c), grid(i, c[4]), grid(j, c[4]), tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    check("R8 reset flag", 32'(flag_o), 0);
    check("R7 reset inv", 32'(inv_o), 0);
    @(negedge clk); rst_n = 1'b1;
    exp_flag = 1'b0;
  endtask

  task automatic t_ordered;     // R10 ordering, R6 lanes, R1 code layout
    sweep(8'h08, 8'h0d, 10, "R10 sp ordered");
    sweep(8'h18, 8'h1d, 10, "R10 dp ordered");
  endtask

  task automatic t_zero;        // R5
    apply(8'h08, 64'h80000000, 64'h0, "R5 sp -0==+0");
    apply(8'h0c, 64'h80000000, 64'h0, "R5 sp -0<+0 false");
    apply(8'h18, 64'h8000000000000000, 64'h0, "R5 dp -0==+0");
    apply(8'h1d, 64'h0, 64'h8000000000000000, "R5 dp +0<=-0");
  endtask

  task automatic t_nan_ordered; // R2
    sweep(8'h08, 8'h0d, 12, "R2 sp nan ordered");
    sweep(8'h18, 8'h1d, 12, "R2 dp nan ordered");
  endtask

  task automatic t_unordered;   // R3
    sweep(8'h28, 8'h2d, 12, "R3 sp unordered-or");
    sweep(8'h38, 8'h3d, 12, "R3 dp unordered-or");
  endtask

  task automatic t_un_test;     // R4
    sweep(8'h2e, 8'h2e, 12, "R4 sp unordered test");
    sweep(8'h3e, 8'h3e, 12, "R4 dp unordered test");
  endtask

  task automatic t_hold;        // R8
    apply(8'h0a, grid(1, 0), grid(0, 0), "R8 set flag");
    a_w0_i = grid(0, 0); b_w0_i = grid(1, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 hold flag idle", 32'(flag_o), 1);
      check("R7 inv idle", 32'(inv_o), 0);
    end
  endtask

  task automatic t_illegal;     // R1
    apply(8'h08, grid(0, 0), grid(0, 0), "R1 set flag");
    apply(8'h0e, grid(11, 0), grid(1, 0), "R1 0x0e illegal");
    apply(8'h1e, grid(10, 1), grid(1, 1), "R1 0x1e illegal");
    apply(8'h0f, grid(1, 0), grid(0, 0), "R1 0x0f illegal");
    apply(8'h48, grid(1, 0), grid(0, 0), "R1 0x48 illegal");
    apply(8'h07, grid(1, 0), grid(0, 0), "R1 0x07 illegal");
    apply(8'h2c, grid(1, 0), grid(0, 0), "R1 clear flag");
    apply(8'hc8, grid(0, 0), grid(0, 0), "R1 0xc8 illegal");
  endtask

  task automatic t_pair;        // R9
    for (int k = 0; k < 32; k += 5) begin
      for (int o = 0; o < 2; o++) begin
        reg_a_i = 5'(k); off_a_i = o[0];
        reg_b_i = 5'(31 - k); off_b_i = !o[0];
        #1;
        check("R9 pair a", 32'(pair_a_o), 32'((k + (o ? 2 : 1)) % 32));
        check("R9 pair b", 32'(pair_b_o), 32'((31 - k + (o ? 1 : 2)) % 32));
      end
    end
    reg_a_i = 5'd31; off_a_i = 1'b1; reg_b_i = 5'd30; off_b_i = 1'b1; #1;
    check("R9 wrap a", 32'(pair_a_o), 1);
    check("R9 wrap b", 32'(pair_b_o), 0);
  endtask

  task automatic t_mid_reset;   // R8
    apply(8'h09, grid(0, 1), grid(1, 1), "R8 set before reset");
    @(negedge clk); rst_n = 1'b0; #1;
    check("R8 reset clears flag", 32'(flag_o), 0);
    @(negedge clk); rst_n = 1'b1; exp_flag = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pair();
    t_zero();
    t_ordered();
    t_nan_ordered();
    t_unordered();
    t_un_test();
    t_hold();
    t_illegal();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule